// File: doc/BRIEF.md
# Conditional Branch Resolver

This block settles conditional branches that the front end has already steered with a guess. Each issued branch lands in one of eight internal station slots, along with its condition code, the guessed direction, its own address, the fall-back address the guess did not pick, and its reorder-buffer tag. Operands that are not yet known arrive as producer tags. The slot watches the result broadcast bus and picks up the matching value by itself.

Once both needed operands are present, the slot can be evaluated. The block evaluates one slot per cycle and frees it. One cycle later it emits a resolution pulse with these fields:
- the true direction;
- a wrong-guess flag, with the fall-back address to redirect fetch to;
- the first reorder-buffer tag to discard, which is the branch tag plus two so that the delay-slot instruction survives;
- a predictor-training write (branch address and true outcome), which is produced on every resolution.

An external flush removes slots whose tags fall inside a discarded tag window.

Top module: `branch_resolver`

## Requirements
- R1: The condition code selects the test. Code 0 is taken when A equals B bit for bit. Code 1 is taken when A differs from B. Code 2 is taken when A, read as signed 32-bit, is zero or positive. Code 3 is taken when signed A is strictly positive.
- R2: A branch issued with all needed operands present raises `resolveValid` for exactly one cycle, at the clock edge right after the edge that accepted it.
- R3: On resolution, `mispredict` is high exactly when the true direction differs from the guessed bit. `redirectAddr` then carries the stored fall-back address. `mispredict` is never high without `resolveValid`.
- R4: `squashTag` equals the branch's reorder-buffer tag plus two, modulo 16 (tag 14 gives 0, tag 15 gives 1).
- R5: Every resolution carries a predictor-training write: `updPc` is the branch address and `updTaken` is the true direction. This holds whether the guess was right or wrong.
- R6: A waiting operand is filled when `cdbValid` is high and `cdbTag` matches its producer tag. A broadcast with another tag leaves it waiting and unchanged. A broadcast in the same cycle as issue, whose tag matches an operand marked not present, fills that operand.
- R7: For codes 2 and 3 the second operand is never waited for. Such a branch resolves even if its B operand is marked not present and never broadcast.
- R8: Among ready slots, the lowest-indexed is evaluated first. At most one slot is evaluated per cycle, and it is freed at that edge. Slots are filled lowest free index first.
- R9: The block holds at most 8 pending branches. `issueReady` is low when all 8 are occupied, and an issue attempted then is discarded with no later resolution.
- R10: While `flushValid` is high, every occupied slot whose tag t satisfies (t - `flushFrom`) mod 16 < (`flushTo` - `flushFrom`) mod 16 is removed, so equal bounds remove nothing. A slot removed in the cycle it is chosen produces no resolution.
- R11: After reset no slot is occupied: `issueReady` is 1 and `resolveValid` and `mispredict` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| issueValid | input | 1 | A new branch is offered |
| issueOp | input | 2 | Condition code (R1) |
| issuePredTaken | input | 1 | Guessed direction |
| issuePc | input | 32 | Branch address |
| issueAltAddr | input | 32 | Address the guess did not pick |
| issueRobTag | input | 4 | Reorder-buffer tag of the branch |
| issueSrcAReady | input | 1 | Operand A value present |
| issueSrcAVal | input | 32 | Operand A value |
| issueSrcATag | input | 4 | Producer tag of operand A |
| issueSrcBReady | input | 1 | Operand B value present |
| issueSrcBVal | input | 32 | Operand B value |
| issueSrcBTag | input | 4 | Producer tag of operand B |
| issueReady | output | 1 | A free slot exists |
| cdbValid | input | 1 | Broadcast bus carries a result |
| cdbTag | input | 4 | Tag of the broadcast result |
| cdbData | input | 32 | Broadcast value |
| flushValid | input | 1 | Discard a tag window |
| flushFrom | input | 4 | First tag of the window |
| flushTo | input | 4 | Tag one past the window |
| resolveValid | output | 1 | One-cycle resolution pulse |
| mispredict | output | 1 | Guess was wrong |
| redirectAddr | output | 32 | Fetch redirect address |
| squashTag | output | 4 | First tag to discard |
| updPc | output | 32 | Predictor write index |
| updTaken | output | 1 | Predictor write outcome |

## Verification
A stale operand flag or a wrongly captured broadcast value shows up as a wrong direction, or as a resolution that arrives early or never comes. Such a fault is visible one edge after the broadcast that should have released the slot. Occupancy errors appear as a resolution carrying an unexpected branch address, a missing or duplicated resolution, or `issueReady` disagreeing with the count of outstanding branches; each of these can be seen within a cycle of the faulty edge. Because slots are drained in a fixed index order, a slot selected in the wrong order shows as resolutions arriving in the wrong sequence.

// File: rtl/br_pkg.sv
package br_pkg;

  localparam int BR_STATIONS = 8;

  typedef enum logic [1:0] {
    BR_EQ  = 2'd0,
    BR_NE  = 2'd1,
    BR_GEZ = 2'd2,
    BR_GTZ = 2'd3
  } brOp_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic [BR_STATIONS-1:0] allocOH;   // slot written by an issue
    logic [BR_STATIONS-1:0] evalOH;    // slot chosen for evaluation
    logic [BR_STATIONS-1:0] clearMask; // slots freed this edge
    logic                   fire;      // chosen slot survives the flush
  } brStrobes_t;

endpackage

// File: rtl/br_ctrl.sv
module br_ctrl
  import br_pkg::*;
#(
  parameter int N = BR_STATIONS
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         issueValid,
  input  logic [N-1:0] opsReady,
  input  logic [N-1:0] flushHit,
  output brStrobes_t   strobes,
  output logic [N-1:0] entryValid,
  output logic         issueReady
);

  logic [N-1:0] validQ;
  logic [N-1:0] allocOH;
  logic [N-1:0] evalOH;
  logic [N-1:0] candidates;
  logic [N-1:0] clearMask;

  // lowest free slot for a new branch
  always_comb begin
    allocOH = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!validQ[i]) allocOH = N'(1) << i;
    end
    if (!issueValid) allocOH = '0;
  end

  // lowest ready slot for evaluation
  assign candidates = validQ & opsReady;
  always_comb begin
    evalOH = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (candidates[i]) evalOH = N'(1) << i;
    end
  end

  assign clearMask = evalOH | (flushHit & validQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) validQ <= '0;
    else       validQ <= (validQ & ~clearMask) | allocOH;
  end

  assign strobes.allocOH   = allocOH;
  assign strobes.evalOH    = evalOH;
  assign strobes.clearMask = clearMask;
  assign strobes.fire      = |(evalOH & ~flushHit);
  assign entryValid        = validQ;
  assign issueReady        = ~&validQ;

endmodule

// File: rtl/br_datapath.sv
module br_datapath
  import br_pkg::*;
#(
  parameter int N      = BR_STATIONS,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int TAG_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  brStrobes_t        strobes,
  input  logic [1:0]        issueOp,
  input  logic              issuePredTaken,
  input  logic [ADDR_W-1:0] issuePc,
  input  logic [ADDR_W-1:0] issueAltAddr,
  input  logic [TAG_W-1:0]  issueRobTag,
  input  logic              issueSrcAReady,
  input  logic [DATA_W-1:0] issueSrcAVal,
  input  logic [TAG_W-1:0]  issueSrcATag,
  input  logic              issueSrcBReady,
  input  logic [DATA_W-1:0] issueSrcBVal,
  input  logic [TAG_W-1:0]  issueSrcBTag,
  input  logic              cdbValid,
  input  logic [TAG_W-1:0]  cdbTag,
  input  logic [DATA_W-1:0] cdbData,
  input  logic              flushValid,
  input  logic [TAG_W-1:0]  flushFrom,
  input  logic [TAG_W-1:0]  flushTo,
  output logic [N-1:0]      opsReady,
  output logic [N-1:0]      flushHit,
  output logic              resolveValid,
  output logic              mispredict,
  output logic [ADDR_W-1:0] redirectAddr,
  output logic [TAG_W-1:0]  squashTag,
  output logic [ADDR_W-1:0] updPc,
  output logic              updTaken
);

  localparam logic [TAG_W-1:0] SPARE_SLOTS = TAG_W'(2);

  logic [DATA_W-1:0] aValQ [N];
  logic [DATA_W-1:0] bValQ [N];
  logic [TAG_W-1:0]  aTagQ [N];
  logic [TAG_W-1:0]  bTagQ [N];
  logic [TAG_W-1:0]  robTagQ [N];
  logic [1:0]        opQ [N];
  logic [ADDR_W-1:0] pcQ [N];
  logic [ADDR_W-1:0] altQ [N];
  logic [N-1:0]      aRdyQ, bRdyQ, predQ;

  // values a new slot starts with, including a same-cycle broadcast
  logic              needB;
  logic              newARdy, newBRdy;
  logic [DATA_W-1:0] newAVal, newBVal;

  always_comb begin
    needB   = (brOp_e'(issueOp) == BR_EQ) || (brOp_e'(issueOp) == BR_NE);
    newARdy = issueSrcAReady || (cdbValid && cdbTag == issueSrcATag);
    newAVal = issueSrcAReady ? issueSrcAVal : cdbData;
    newBRdy = !needB || issueSrcBReady || (cdbValid && cdbTag == issueSrcBTag);
    newBVal = issueSrcBReady ? issueSrcBVal : cdbData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aRdyQ <= '0;
      bRdyQ <= '0;
      predQ <= '0;
      for (int i = 0; i < N; i++) begin
        aValQ[i]   <= '0;
        bValQ[i]   <= '0;
        aTagQ[i]   <= '0;
        bTagQ[i]   <= '0;
        robTagQ[i] <= '0;
        opQ[i]     <= '0;
        pcQ[i]     <= '0;
        altQ[i]    <= '0;
      end
    end else begin
      for (int i = 0; i < N; i++) begin
        if (strobes.allocOH[i]) begin
          opQ[i]     <= issueOp;
          predQ[i]   <= issuePredTaken;
          pcQ[i]     <= issuePc;
          altQ[i]    <= issueAltAddr;
          robTagQ[i] <= issueRobTag;
          aTagQ[i]   <= issueSrcATag;
          bTagQ[i]   <= issueSrcBTag;
          aRdyQ[i]   <= newARdy;
          aValQ[i]   <= newAVal;
          bRdyQ[i]   <= newBRdy;
          bValQ[i]   <= newBVal;
        end else begin
          if (!aRdyQ[i] && cdbValid && cdbTag == aTagQ[i]) begin
            aRdyQ[i] <= 1'b1;
            aValQ[i] <= cdbData;
          end
          if (!bRdyQ[i] && cdbValid && cdbTag == bTagQ[i]) begin
            bRdyQ[i] <= 1'b1;
            bValQ[i] <= cdbData;
          end
        end
      end
    end
  end

  // per-slot readiness and flush window membership
  always_comb begin
    logic [TAG_W-1:0] span;
    logic [TAG_W-1:0] offs;
    span = flushTo - flushFrom;
    for (int i = 0; i < N; i++) begin
      opsReady[i] = aRdyQ[i] & bRdyQ[i];
      offs        = robTagQ[i] - flushFrom;
      flushHit[i] = flushValid && (offs < span);
    end
  end

  // pick the chosen slot's contents
  logic [DATA_W-1:0] selA, selB;
  logic [ADDR_W-1:0] selPc, selAlt;
  logic [TAG_W-1:0]  selTag;
  logic [1:0]        selOp;
  logic              selPred;
  logic              actualTaken;

  always_comb begin
    selA    = '0;
    selB    = '0;
    selPc   = '0;
    selAlt  = '0;
    selTag  = '0;
    selOp   = '0;
    selPred = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (strobes.evalOH[i]) begin
        selA    = selA | aValQ[i];
        selB    = selB | bValQ[i];
        selPc   = selPc | pcQ[i];
        selAlt  = selAlt | altQ[i];
        selTag  = selTag | robTagQ[i];
        selOp   = selOp | opQ[i];
        selPred = selPred | predQ[i];
      end
    end
  end

  always_comb begin
    unique case (brOp_e'(selOp))
      BR_EQ:   actualTaken = (selA == selB);
      BR_NE:   actualTaken = (selA != selB);
      BR_GEZ:  actualTaken = !selA[DATA_W-1];
      BR_GTZ:  actualTaken = !selA[DATA_W-1] && (|selA);
      default: actualTaken = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resolveValid <= 1'b0;
      mispredict   <= 1'b0;
      redirectAddr <= '0;
      squashTag    <= '0;
      updPc        <= '0;
      updTaken     <= 1'b0;
    end else if (strobes.fire) begin
      resolveValid <= 1'b1;
      mispredict   <= actualTaken ^ selPred;
      redirectAddr <= selAlt;
      squashTag    <= selTag + SPARE_SLOTS;
      updPc        <= selPc;
      updTaken     <= actualTaken;
    end else begin
      resolveValid <= 1'b0;
      mispredict   <= 1'b0;
    end
  end

endmodule

// File: rtl/branch_resolver.sv
module branch_resolver
  import br_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int TAG_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              issueValid,
  input  logic [1:0]        issueOp,
  input  logic              issuePredTaken,
  input  logic [ADDR_W-1:0] issuePc,
  input  logic [ADDR_W-1:0] issueAltAddr,
  input  logic [TAG_W-1:0]  issueRobTag,
  input  logic              issueSrcAReady,
  input  logic [DATA_W-1:0] issueSrcAVal,
  input  logic [TAG_W-1:0]  issueSrcATag,
  input  logic              issueSrcBReady,
  input  logic [DATA_W-1:0] issueSrcBVal,
  input  logic [TAG_W-1:0]  issueSrcBTag,
  output logic              issueReady,
  input  logic              cdbValid,
  input  logic [TAG_W-1:0]  cdbTag,
  input  logic [DATA_W-1:0] cdbData,
  input  logic              flushValid,
  input  logic [TAG_W-1:0]  flushFrom,
  input  logic [TAG_W-1:0]  flushTo,
  output logic              resolveValid,
  output logic              mispredict,
  output logic [ADDR_W-1:0] redirectAddr,
  output logic [TAG_W-1:0]  squashTag,
  output logic [ADDR_W-1:0] updPc,
  output logic              updTaken
);

  localparam int N = BR_STATIONS;

  brStrobes_t   strobes;
  logic [N-1:0] opsReady;
  logic [N-1:0] flushHit;
  logic [N-1:0] entryValid;

  br_ctrl #(.N(N)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .issueValid(issueValid),
    .opsReady  (opsReady),
    .flushHit  (flushHit),
    .strobes   (strobes),
    .entryValid(entryValid),
    .issueReady(issueReady)
  );

  br_datapath #(.N(N), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .TAG_W(TAG_W)) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .strobes       (strobes),
    .issueOp       (issueOp),
    .issuePredTaken(issuePredTaken),
    .issuePc       (issuePc),
    .issueAltAddr  (issueAltAddr),
    .issueRobTag   (issueRobTag),
    .issueSrcAReady(issueSrcAReady),
    .issueSrcAVal  (issueSrcAVal),
    .issueSrcATag  (issueSrcATag),
    .issueSrcBReady(issueSrcBReady),
    .issueSrcBVal  (issueSrcBVal),
    .issueSrcBTag  (issueSrcBTag),
    .cdbValid      (cdbValid),
    .cdbTag        (cdbTag),
    .cdbData       (cdbData),
    .flushValid    (flushValid),
    .flushFrom     (flushFrom),
    .flushTo       (flushTo),
    .opsReady      (opsReady),
    .flushHit      (flushHit),
    .resolveValid  (resolveValid),
    .mispredict    (mispredict),
    .redirectAddr  (redirectAddr),
    .squashTag     (squashTag),
    .updPc         (updPc),
    .updTaken      (updTaken)
  );

endmodule

// File: rtl/br_resolver_checker.sv
module br_resolver_checker #(
  parameter int N = 8
) (
  input logic         clk,
  input logic         rstN,
  input logic [N-1:0] entryValid,
  input logic [N-1:0] opsReady,
  input logic [N-1:0] allocOH,
  input logic [N-1:0] evalOH,
  input logic         fire,
  input logic         resolveValid,
  input logic         mispredict
);

  // R9: an issue never lands on an occupied slot
  a_r9_no_overwrite: assert property (@(posedge clk) disable iff (!rstN)
    (allocOH & entryValid) == '0);

  // R8: at most one slot evaluated per cycle
  a_r8_single_eval: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(evalOH));

  // R8: only an occupied, ready slot is evaluated
  a_r8_eval_ready: assert property (@(posedge clk) disable iff (!rstN)
    (evalOH & ~(entryValid & opsReady)) == '0);

  // R8: the evaluated slot is free on the next cycle
  a_r8_freed: assert property (@(posedge clk) disable iff (!rstN)
    fire |=> ((entryValid & $past(evalOH)) == '0));

  // R3: a wrong guess is only flagged with a resolution
  a_r3_flag_in_pulse: assert property (@(posedge clk) disable iff (!rstN)
    mispredict |-> resolveValid);

  // R2: each resolution follows an evaluation one edge earlier
  a_r2_pulse_source: assert property (@(posedge clk) disable iff (!rstN)
    resolveValid |-> $past(fire));

endmodule

bind branch_resolver br_resolver_checker #(.N(br_pkg::BR_STATIONS)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .entryValid  (entryValid),
  .opsReady    (opsReady),
  .allocOH     (strobes.allocOH),
  .evalOH      (strobes.evalOH),
  .fire        (strobes.fire),
  .resolveValid(resolveValid),
  .mispredict  (mispredict)
);

// File: tb/tb_branch_resolver.sv
module tb_branch_resolver;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        issueValid = 1'b0;
  logic [1:0]  issueOp = '0;
  logic        issuePredTaken = 1'b0;
  logic [31:0] issuePc = '0;
  logic [31:0] issueAltAddr = '0;
  logic [3:0]  issueRobTag = '0;
  logic        issueSrcAReady = 1'b0;
  logic [31:0] issueSrcAVal = '0;
  logic [3:0]  issueSrcATag = '0;
  logic        issueSrcBReady = 1'b0;
  logic [31:0] issueSrcBVal = '0;
  logic [3:0]  issueSrcBTag = '0;
  logic        issueReady;
  logic        cdbValid = 1'b0;
  logic [3:0]  cdbTag = '0;
  logic [31:0] cdbData = '0;
  logic        flushValid = 1'b0;
  logic [3:0]  flushFrom = '0;
  logic [3:0]  flushTo = '0;
  logic        resolveValid;
  logic        mispredict;
  logic [31:0] redirectAddr;
  logic [3:0]  squashTag;
  logic [31:0] updPc;
  logic        updTaken;

  int testCount = 0;
  int failCount = 0;
  bit finished  = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  branch_resolver dut (.*);

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  // drive one issue for one cycle; returns at the negedge after acceptance
  task automatic doIssue(input logic [1:0] op, input logic pred, input logic [31:0] pc,
                         input logic [31:0] alt, input logic [3:0] tag,
                         input logic aR, input logic [31:0] aV, input logic [3:0] aT,
                         input logic bR, input logic [31:0] bV, input logic [3:0] bT);
    issueValid = 1'b1; issueOp = op; issuePredTaken = pred; issuePc = pc;
    issueAltAddr = alt; issueRobTag = tag;
    issueSrcAReady = aR; issueSrcAVal = aV; issueSrcATag = aT;
    issueSrcBReady = bR; issueSrcBVal = bV; issueSrcBTag = bT;
    step(1);
    issueValid = 1'b0;
  endtask

  task automatic broadcast(input logic [3:0] tag, input logic [31:0] data);
    cdbValid = 1'b1; cdbTag = tag; cdbData = data;
    step(1);
    cdbValid = 1'b0;
  endtask

  task automatic flush(input logic [3:0] from, input logic [3:0] upTo);
    flushValid = 1'b1; flushFrom = from; flushTo = upTo;
    step(1);
    flushValid = 1'b0;
  endtask

  function automatic logic refTaken(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b);
    case (op)
      2'd0:    return a == b;
      2'd1:    return a != b;
      2'd2:    return $signed(a) >= 0;
      default: return $signed(a) > 0;
    endcase
  endfunction

  initial begin : watchdog
    for (int c = 0; c < 100000; c++) begin
      @(posedge clk);
      if (finished) disable watchdog;
    end
    failCount++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    logic [31:0] aList [5];
    logic [31:0] a, b, pc, alt;
    logic [3:0]  tag;
    logic        exp;
    int          it;
    aList[0] = 32'h0; aList[1] = 32'h1; aList[2] = 32'hFFFF_FFFF;
    aList[3] = 32'h8000_0000; aList[4] = 32'h7FFF_FFFF;

    step(3);
    rstN = 1'b1;
    step(1);
    // R11 reset state
    check("R11 issueReady", issueReady, 1);
    check("R11 resolveValid", resolveValid, 0);
    check("R11 mispredict", mispredict, 0);

    // R1 R2 R3 R4 R5 sweep with ready operands
    it = 0;
    for (int op = 0; op < 4; op++) begin
      for (int pr = 0; pr < 2; pr++) begin
        for (int ai = 0; ai < 5; ai++) begin
          for (int bi = 0; bi < 3; bi++) begin
            a   = aList[ai];
            b   = (bi == 0) ? a : (bi == 1) ? (a ^ 32'h1) : 32'h0;
            pc  = 32'h1000 + 32'(it) * 8;
            alt = pc ^ 32'h0004_0400;
            tag = 4'(it);
            exp = refTaken(2'(op), a, b);
            doIssue(2'(op), pr[0], pc, alt, tag, 1'b1, a, 4'd0, 1'b1, b, 4'd0);
            check("R2 not before next edge", resolveValid, 0);
            step(1);
            check("R2 resolveValid", resolveValid, 1);
            check("R1 updTaken", updTaken, exp);
            check("R3 mispredict", mispredict, exp ^ pr[0]);
            check("R3 redirectAddr", redirectAddr, alt);
            check("R4 squashTag", squashTag, 4'(tag + 4'd2));
            check("R5 updPc", updPc, pc);
            step(1);
            check("R2 single pulse", resolveValid, 0);
            it++;
          end
        end
      end
    end

    // R6 capture from the bus, ignoring other tags
    doIssue(2'd1, 1'b0, 32'h2000, 32'h2100, 4'd3, 1'b0, 32'h0, 4'd5, 1'b1, 32'd3, 4'd0);
    step(2);
    check("R6 waits for operand", resolveValid, 0);
    broadcast(4'd6, 32'd9);
    step(1);
    check("R6 wrong tag ignored", resolveValid, 0);
    broadcast(4'd5, 32'd3);
    check("R6 ready after capture edge", resolveValid, 0);
    step(1);
    check("R6 resolves after capture", resolveValid, 1);
    check("R6 captured value used", updTaken, 0);
    check("R6 pc", updPc, 32'h2000);
    step(1);

    // R6 capture of B operand
    doIssue(2'd0, 1'b0, 32'h2200, 32'h2300, 4'd4, 1'b1, 32'd11, 4'd0, 1'b0, 32'h0, 4'd8);
    broadcast(4'd8, 32'd11);
    step(1);
    check("R6 B captured", resolveValid, 1);
    check("R6 B value", updTaken, 1);
    check("R3 taken vs not-taken guess", mispredict, 1);
    step(1);

    // R6 same-cycle issue and broadcast
    cdbValid = 1'b1; cdbTag = 4'd2; cdbData = 32'd7;
    doIssue(2'd0, 1'b1, 32'h2400, 32'h2500, 4'd6, 1'b0, 32'h0, 4'd2, 1'b1, 32'd7, 4'd0);
    cdbValid = 1'b0;
    step(1);
    check("R6 same-cycle capture", resolveValid, 1);
    check("R6 same-cycle value", updTaken, 1);
    check("R3 correct guess", mispredict, 0);
    step(1);

    // R7 B never waited for on sign tests
    doIssue(2'd3, 1'b0, 32'h2600, 32'h2700, 4'd7, 1'b1, 32'd4, 4'd0, 1'b0, 32'h0, 4'd9);
    step(1);
    check("R7 gtz ignores B", resolveValid, 1);
    check("R7 gtz taken", updTaken, 1);
    step(1);
    doIssue(2'd2, 1'b1, 32'h2800, 32'h2900, 4'd8, 1'b1, 32'hFFFF_FFF0, 4'd0, 1'b0, 32'h0, 4'd9);
    step(1);
    check("R7 gez ignores B", resolveValid, 1);
    check("R7 gez negative", updTaken, 0);
    step(1);

    // R8 lowest index first, one per cycle
    for (int i = 0; i < 3; i++)
      doIssue(2'd0, 1'b0, 32'h3000 + 32'(i) * 4, 32'h0, 4'(i), 1'b0, 32'h0, 4'd1, 1'b1, 32'h0, 4'd0);
    broadcast(4'd1, 32'h0);
    for (int i = 0; i < 3; i++) begin
      step(1);
      check("R8 order valid", resolveValid, 1);
      check("R8 order pc", updPc, 32'h3000 + 32'(i) * 4);
    end
    step(1);
    check("R8 drained", resolveValid, 0);

    // R9 capacity
    for (int i = 0; i < 8; i++)
      doIssue(2'd1, 1'b0, 32'h4000 + 32'(i) * 4, 32'h0, 4'(i), 1'b0, 32'h0, 4'd3, 1'b1, 32'h0, 4'd0);
    check("R9 full", issueReady, 0);
    doIssue(2'd0, 1'b0, 32'hDEAD, 32'h0, 4'd9, 1'b1, 32'h0, 4'd0, 1'b1, 32'h0, 4'd0);
    step(1);
    check("R9 dropped issue", resolveValid, 0);
    broadcast(4'd3, 32'h5);
    for (int i = 0; i < 8; i++) begin
      step(1);
      check("R9 drain valid", resolveValid, 1);
      check("R9 drain pc", updPc, 32'h4000 + 32'(i) * 4);
    end
    step(1);
    check("R9 nothing extra", resolveValid, 0);
    step(1);
    check("R9 nothing extra later", resolveValid, 0);
    check("R9 free again", issueReady, 1);

    // R10 flush window without wrap
    doIssue(2'd0, 1'b0, 32'h5003, 32'h0, 4'd3, 1'b0, 32'h0, 4'd6, 1'b1, 32'h0, 4'd0);
    doIssue(2'd0, 1'b0, 32'h5004, 32'h0, 4'd4, 1'b0, 32'h0, 4'd6, 1'b1, 32'h0, 4'd0);
    doIssue(2'd0, 1'b0, 32'h5009, 32'h0, 4'd9, 1'b0, 32'h0, 4'd6, 1'b1, 32'h0, 4'd0);
    flush(4'd4, 4'd9);
    broadcast(4'd6, 32'h0);
    step(1);
    check("R10 survivor tag3", updPc, 32'h5003);
    check("R4 tag3", squashTag, 4'd5);
    step(1);
    check("R10 survivor tag9", updPc, 32'h5009);
    check("R10 tag9 valid", resolveValid, 1);
    step(1);
    check("R10 tag4 removed", resolveValid, 0);

    // R10 wrapping window
    for (int i = 0; i < 4; i++)
      doIssue(2'd0, 1'b0, 32'h6000 + 32'(i), 32'h0, 4'(15 + i), 1'b0, 32'h0, 4'd7, 1'b1, 32'h0, 4'd0);
    flush(4'd15, 4'd2);
    broadcast(4'd7, 32'h0);
    step(1);
    check("R10 wrap survivor", updPc, 32'h6003);
    check("R10 wrap squash", squashTag, 4'd4);
    step(1);
    check("R10 wrap removed", resolveValid, 0);

    // R10 empty window
    doIssue(2'd0, 1'b0, 32'h7000, 32'h0, 4'd5, 1'b0, 32'h0, 4'd2, 1'b1, 32'h0, 4'd0);
    flush(4'd5, 4'd5);
    broadcast(4'd2, 32'h0);
    step(1);
    check("R10 empty window keeps", resolveValid, 1);
    step(1);

    // R10 flushed in the cycle it is chosen
    doIssue(2'd0, 1'b0, 32'h7100, 32'h0, 4'd10, 1'b1, 32'h0, 4'd0, 1'b1, 32'h0, 4'd0);
    flush(4'd10, 4'd11);
    check("R10 chosen then flushed", resolveValid, 0);
    step(1);
    check("R10 stays gone", resolveValid, 0);
    check("R10 slot freed", issueReady, 1);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

endmodule